// File: doc/BRIEF.md
# Status Word and Interrupt Mask Controller

This block keeps the 16-bit status word of a serial network master and drives its active-low interrupt line. Six event inputs arrive as single-cycle pulses: cycle end, break frame received, input-port change, data-communication error, address error and communication alarm. Each pulse sets a sticky flag in the low part of the word. The upper four bits show live busy conditions taken straight from the controller's state: cyclic traffic running, reset in progress, data or system traffic in progress, and break traffic in progress.

The host clears sticky flags by writing a word to the clear port. Each bit written as 1 clears the flag at that position. A configuration input can turn this clear path off, and while it is off clear writes have no effect. A companion mask word holds one bit per event source. A set mask bit keeps that source off the interrupt line, but the flag still records the event. The interrupt output is low whenever some set flag is not masked.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset the status flags read 0, the mask word reads 0 and `irq_n_o` is 1.
- R2: A pulse on `evt_i[k]` (bit 0 cycle end, 1 break frame, 2 input change, 3 data error, 4 address error, 5 alarm) makes `status_o[k]` read 1 from the following clock on. The flag stays 1 until it is cleared.
- R3: With `clr_en_i`=1, a clock on which `clr_we_i`=1 clears every flag whose bit in `clr_data_i` is 1. It leaves every other flag unchanged.
- R4: With `clr_en_i`=0, a clear write changes no flag.
- R5: When a flag's event and a clear of that same flag fall on the same clock, the flag reads 1 afterwards.
- R6: `status_o[12]` equals `cyc_run_i`, `status_o[13]` equals `rst_busy_i`, `status_o[14]` equals `dat_busy_i` and `status_o[15]` equals `brk_busy_i`, in the same cycle and with no register.
- R7: A clock with `msk_we_i`=1 loads `msk_data_i[5:0]` into the mask. `mask_o[k]`=1 masks source k. `mask_o[15:6]` always reads 0.
- R8: `irq_n_o` is 0 exactly when some k has `status_o[k]`=1 and `mask_o[k]`=0. This holds in the same cycle as the flag and mask outputs.
- R9: A masked source still sets its flag. Unmasking it later with its flag still set pulls `irq_n_o` low.
- R10: `status_o[11:6]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses, one bit per source |
| cyc_run_i | input | 1 | Cyclic traffic running |
| rst_busy_i | input | 1 | Reset in progress |
| dat_busy_i | input | 1 | Data or system traffic in progress |
| brk_busy_i | input | 1 | Break traffic in progress |
| clr_en_i | input | 1 | Configuration bit that enables flag clearing |
| clr_we_i | input | 1 | Clear-word write strobe |
| clr_data_i | input | 16 | Clear word; a 1 clears that flag |
| msk_we_i | input | 1 | Mask-word write strobe |
| msk_data_i | input | 16 | New mask word |
| status_o | output | 16 | Status word |
| mask_o | output | 16 | Mask word |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach is a collision: an event and a clear of the same flag on one clock, with the clear path enabled. Clears that hit only some of the set flags while other flags are being set are also hard to produce. Random stimulus seldom lines these up, so directed steps force each collision. A long random phase then draws sparse event pulses, random clear words, random toggling of the enable bit and occasional mask rewrites. Every step is compared with a bench model, including the case of a masked flag that stays set and then raises the interrupt once it is unmasked.

// File: rtl/stat_irq_pkg.sv
`timescale 1ns/1ps
package stat_irq_pkg;
   localparam int WORD_W    = 16;
   localparam int BUSY_BASE = 12;
   localparam int BUSY_N    = 4;
   localparam int POS_CYC   = BUSY_BASE + 0;
   localparam int POS_RST   = BUSY_BASE + 1;
   localparam int POS_DAT   = BUSY_BASE + 2;
   localparam int POS_BRK   = BUSY_BASE + 3;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      logic brk;
      logic dat;
      logic rst;
      logic cyc;
   } busy_t;
endpackage

// File: rtl/sif_flag_bank.sv
`timescale 1ns/1ps
module sif_flag_bank #(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               clr_go,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] flags
);
   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hold_q <= 1'b0;
            else if (evt[k])
               hold_q <= 1'b1;
            else if (clr_go && clr_bits[k])
               hold_q <= 1'b0;
         end
         assign flags[k] = hold_q;
      end
   endgenerate
endmodule

// File: rtl/sif_mask_reg.sv
`timescale 1ns/1ps
module sif_mask_reg #(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [NUM_SRC-1:0] din,
   output logic [NUM_SRC-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask <= '0;
      else if (we)
         mask <= din;
   end
endmodule

// File: rtl/sif_status_pack.sv
`timescale 1ns/1ps
module sif_status_pack
   import stat_irq_pkg::*;
#(
   parameter int NUM_SRC = 6
) (
   input  logic [NUM_SRC-1:0] flags,
   input  busy_t              busy,
   output word_t              word
);
   localparam int GAP_LO = NUM_SRC;
   localparam int GAP_N  = BUSY_BASE - NUM_SRC;

   assign word[NUM_SRC-1:0] = flags;
   generate
      if (GAP_N > 0) begin : g_gap
         assign word[BUSY_BASE-1:GAP_LO] = '0;
      end
   endgenerate
   assign word[POS_CYC] = busy.cyc;
   assign word[POS_RST] = busy.rst;
   assign word[POS_DAT] = busy.dat;
   assign word[POS_BRK] = busy.brk;
endmodule

// File: rtl/sif_irq_gen.sv
`timescale 1ns/1ps
module sif_irq_gen #(
   parameter int NUM_SRC = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] flags,
   input  logic [NUM_SRC-1:0] mask,
   output logic               irq_n
);
   logic pend;
   assign pend = |(flags & ~mask);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b1;
            else
               irq_q <= ~pend;
         end
         assign irq_n = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_n = ~pend;
      end
   endgenerate
endmodule

// File: rtl/stat_irq_ctrl.sv
`timescale 1ns/1ps
module stat_irq_ctrl
   import stat_irq_pkg::*;
#(
   parameter int NUM_SRC = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               cyc_run_i,
   input  logic               rst_busy_i,
   input  logic               dat_busy_i,
   input  logic               brk_busy_i,
   input  logic               clr_en_i,
   input  logic               clr_we_i,
   input  logic [WORD_W-1:0]  clr_data_i,
   input  logic               msk_we_i,
   input  logic [WORD_W-1:0]  msk_data_i,
   output logic [WORD_W-1:0]  status_o,
   output logic [WORD_W-1:0]  mask_o,
   output logic               irq_n_o
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > BUSY_BASE) begin : g_bad_src
         $error("stat_irq_ctrl: NUM_SRC must lie in 1..%0d", BUSY_BASE);
      end
      if (BUSY_BASE + BUSY_N != WORD_W) begin : g_bad_word
         $error("stat_irq_ctrl: busy field must end at the top of the word");
      end
   endgenerate

   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] mask;
   busy_t              busy;
   logic               unused_hi;

   generate
      if (NUM_SRC < WORD_W) begin : g_hi
         assign unused_hi = ^{clr_data_i[WORD_W-1:NUM_SRC], msk_data_i[WORD_W-1:NUM_SRC]};
         assign mask_o[WORD_W-1:NUM_SRC] = '0;
      end else begin : g_nohi
         assign unused_hi = 1'b0;
      end
   endgenerate

   assign busy = '{brk: brk_busy_i, dat: dat_busy_i, rst: rst_busy_i, cyc: cyc_run_i};

   sif_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i),
      .clr_go   (clr_we_i & clr_en_i),
      .clr_bits (clr_data_i[NUM_SRC-1:0]),
      .flags    (flags)
   );

   sif_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (msk_we_i),
      .din   (msk_data_i[NUM_SRC-1:0]),
      .mask  (mask)
   );

   sif_status_pack #(.NUM_SRC(NUM_SRC)) u_pack (
      .flags (flags),
      .busy  (busy),
      .word  (status_o)
   );

   sif_irq_gen #(.NUM_SRC(NUM_SRC), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .mask  (mask),
      .irq_n (irq_n_o)
   );

   assign mask_o[NUM_SRC-1:0] = mask;
endmodule

// File: rtl/stat_irq_ctrl_chk.sv
`timescale 1ns/1ps
module stat_irq_ctrl_chk #(
   parameter int NUM_SRC = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               cyc_run_i,
   input logic               rst_busy_i,
   input logic               dat_busy_i,
   input logic               brk_busy_i,
   input logic               clr_en_i,
   input logic               clr_we_i,
   input logic [15:0]        clr_data_i,
   input logic [15:0]        status_o,
   input logic [15:0]        mask_o,
   input logic               irq_n_o
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((status_o[NUM_SRC-1:0] & $past(evt_i)) == $past(evt_i)));

   a_r3_clear_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(clr_we_i && clr_en_i)) |->
      ((status_o[NUM_SRC-1:0] & $past(clr_data_i[NUM_SRC-1:0] & ~evt_i)) == '0));

   a_r4_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(!(clr_we_i && clr_en_i))) |->
      ((status_o[NUM_SRC-1:0] & $past(status_o[NUM_SRC-1:0])) == $past(status_o[NUM_SRC-1:0])));

   a_r6_busy_live: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[15:12] == {brk_busy_i, dat_busy_i, rst_busy_i, cyc_run_i});

   a_r7_mask_upper: assert property (@(posedge clk) disable iff (!rst_n)
      mask_o[15:NUM_SRC] == '0);

   a_r10_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[11:NUM_SRC] == '0);

   generate
      if (!IRQ_REG) begin : g_irq_chk
         a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
            irq_n_o == !(|(status_o[NUM_SRC-1:0] & ~mask_o[NUM_SRC-1:0])));
      end
   endgenerate
endmodule

bind stat_irq_ctrl stat_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .IRQ_REG(IRQ_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_i      (evt_i),
   .cyc_run_i  (cyc_run_i),
   .rst_busy_i (rst_busy_i),
   .dat_busy_i (dat_busy_i),
   .brk_busy_i (brk_busy_i),
   .clr_en_i   (clr_en_i),
   .clr_we_i   (clr_we_i),
   .clr_data_i (clr_data_i),
   .status_o   (status_o),
   .mask_o     (mask_o),
   .irq_n_o    (irq_n_o)
);

// File: tb/stat_irq_ctrl_tb.sv
`timescale 1ns/1ps
module stat_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  evt_i = '0;
   logic        cyc_run_i = 1'b0, rst_busy_i = 1'b0, dat_busy_i = 1'b0, brk_busy_i = 1'b0;
   logic        clr_en_i = 1'b0, clr_we_i = 1'b0, msk_we_i = 1'b0;
   logic [15:0] clr_data_i = '0, msk_data_i = '0;
   logic [15:0] status_o, mask_o;
   logic        irq_n_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [5:0] m_flags = '0;
   logic [5:0] m_mask  = '0;
   logic [3:0] m_busy  = '0;

   always #2.5 clk = ~clk;

   stat_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .cyc_run_i(cyc_run_i), .rst_busy_i(rst_busy_i),
      .dat_busy_i(dat_busy_i), .brk_busy_i(brk_busy_i),
      .clr_en_i(clr_en_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
      .msk_we_i(msk_we_i), .msk_data_i(msk_data_i),
      .status_o(status_o), .mask_o(mask_o), .irq_n_o(irq_n_o)
   );

   function automatic logic [15:0] exp_status();
      return {m_busy, 6'b0, m_flags};
   endfunction

   function automatic logic exp_irq();
      return ~|(m_flags & ~m_mask);
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [5:0] evt, input logic [3:0] busy,
                       input logic cen, input logic cwe, input logic [15:0] cdat,
                       input logic mwe, input logic [15:0] mdat);
      evt_i = evt;
      {brk_busy_i, dat_busy_i, rst_busy_i, cyc_run_i} = busy;
      clr_en_i = cen; clr_we_i = cwe; clr_data_i = cdat;
      msk_we_i = mwe; msk_data_i = mdat;
      m_flags = (m_flags & ~((cen && cwe) ? cdat[5:0] : 6'h00)) | evt;
      if (mwe) m_mask = mdat[5:0];
      m_busy = busy;
      @(posedge clk);
      @(negedge clk);
      evt_i = '0; clr_we_i = 1'b0; msk_we_i = 1'b0;
   endtask

   task automatic idle();
      step(6'h00, m_busy, clr_en_i, 1'b0, 16'h0, 1'b0, 16'h0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      chk("R1 status during reset", status_o, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", status_o, 16'h0000);
      chk("R1 mask after reset", mask_o, 16'h0000);
      chk("R1 irq after reset", {15'b0, irq_n_o}, 16'h0001);

      step(6'h01, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0);
      chk("R2 cycle-end flag set", status_o, 16'h0001);
      chk("R8 irq asserted", {15'b0, irq_n_o}, 16'h0000);
      idle();
      chk("R2 flag sticky", status_o, 16'h0001);

      step(6'h00, 4'h0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 16'h0);
      chk("R4 clear ignored when disabled", status_o, 16'h0001);
      chk("R4 irq unchanged", {15'b0, irq_n_o}, 16'h0000);

      step(6'h20, 4'h0, 1'b1, 1'b1, 16'h0002, 1'b0, 16'h0);
      chk("R3 other bits untouched", status_o, 16'h0021);
      step(6'h00, 4'h0, 1'b1, 1'b1, 16'h0001, 1'b0, 16'h0);
      chk("R3 selected bit cleared", status_o, 16'h0020);
      step(6'h00, 4'h0, 1'b1, 1'b1, 16'h0020, 1'b0, 16'h0);
      chk("R3 all cleared", status_o, 16'h0000);
      chk("R8 irq released", {15'b0, irq_n_o}, 16'h0001);

      step(6'h08, 4'h0, 1'b1, 1'b1, 16'h0008, 1'b0, 16'h0);
      chk("R5 event wins over clear", status_o, 16'h0008);
      step(6'h00, 4'h0, 1'b1, 1'b1, 16'h0008, 1'b0, 16'h0);
      chk("R3 clear after collision", status_o, 16'h0000);

      step(6'h00, 4'h0, 1'b1, 1'b0, 16'h0, 1'b1, 16'hFFFF);
      chk("R7 mask upper bits zero", mask_o, 16'h003F);
      step(6'h10, 4'h0, 1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
      chk("R9 masked flag recorded", status_o, 16'h0010);
      chk("R9 masked irq stays high", {15'b0, irq_n_o}, 16'h0001);
      step(6'h00, 4'h0, 1'b1, 1'b0, 16'h0, 1'b1, 16'h0005);
      chk("R7 mask loaded", mask_o, 16'h0005);
      chk("R9 unmask raises irq", {15'b0, irq_n_o}, 16'h0000);

      for (int b = 0; b < 16; b++) begin
         step(6'h00, b[3:0], 1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
         chk("R6 busy bits live", {12'h0, status_o[15:12]}, {12'h0, b[3:0]});
         chk("R10 gap bits zero", {10'h0, status_o[11:6]}, 16'h0000);
      end

      for (int i = 0; i < 2000; i++) begin
         logic [5:0]  ev;
         logic [15:0] cd, md;
         logic        ce, cw, mw;
         ev = 6'($urandom & $urandom & $urandom);
         cd = 16'($urandom);
         ce = ($urandom % 4) != 0;
         cw = ($urandom % 3) == 0;
         mw = ($urandom % 10) == 0;
         md = 16'($urandom);
         step(ev, 4'($urandom), ce, cw, cd, mw, md);
         chk("R2/R3 random status", status_o, exp_status());
         chk("R7 random mask", mask_o, {10'h0, m_mask});
         chk("R8 random irq", {15'b0, irq_n_o}, {15'b0, exp_irq()});
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule